// File: doc/BRIEF.md
# Auto-Incrementing Shared-RAM Access Port

This block is a byte-wide window of four registers. Through it a host CPU reaches the private RAM of a coprocessor indirectly. The host loads a 16-bit pointer one byte at a time. It then moves bytes through a single data register, which reads or writes the RAM byte under the pointer. When auto-increment is enabled, the pointer steps forward after every data access. A code image can then be uploaded, downloaded or compared after loading the address only once.

The same window also controls the coprocessor. A control register holds a run bit, and the coprocessor is held in reset while that bit is clear. Writing a one to the request bit sends a one-cycle interrupt request to the coprocessor. The coprocessor reports back through two event strobes. Each strobe latches a pending flag, and the flags share one level-sensitive host interrupt line. The host clears a flag by writing a one to its bit. A heartbeat protocol runs on top of the plain data path: the coprocessor writes 0xFF to an agreed RAM byte, and the host reads that byte and writes it back to zero.

The RAM side is a plain synchronous port with a read latency of one cycle. Host reads of any register therefore complete one cycle after the request, marked by a valid strobe.

Top module: `cpx_window`

## Requirements
- R1: After reset the pointer is 0x0000, run and auto-increment are 0, both event flags are clear, `cop_reset` is 1 and `cop_run`, `cop_irq` and `host_irq` are 0.
- R2: Register index 0 writes pointer bits 7:0 and index 1 writes pointer bits 15:8. Reading either index returns that byte on `host_rdata` in the cycle after the request, with `host_rvalid` high in that cycle.
- R3: A host write to index 2 (data) drives `ram_we` in the same cycle, with `ram_wdata` equal to the host byte and `ram_addr` equal to the current pointer.
- R4: A host read of index 2 drives `ram_re` at the current pointer in the same cycle. In the next cycle, while `host_rvalid` is high, it returns the byte stored at the pointer value from before any increment.
- R5: Control bit 1 (auto-increment) set makes the pointer advance by one after every data read or write. With the bit clear, data accesses leave the pointer unchanged.
- R6: The pointer wraps from 0xFFFF to 0x0000 on increment.
- R7: Control bit 0 (run) drives `cop_run`, and `cop_reset` is its inverse. Both change in the cycle after the control write.
- R8: Writing control bit 2 as 1 pulses `cop_irq` high for exactly one cycle, the cycle after the write. Bit 2 always reads back as 0.
- R9: A high on `evt_set[0]` sets the event flag at control bit 4, and a high on `evt_set[1]` sets the flag at bit 5. `host_irq` is high while either flag is set.
- R10: Writing 1 to control bit 4 or 5 clears that flag. Writing 0 to it leaves it unchanged.
- R11: If an event strobe and a host clear hit the same flag in the same cycle, the flag ends up set.
- R12: A control read returns run at bit 0, auto-increment at bit 1 and the event flags at bits 4 and 5. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_rd | input | 1 | Host read strobe for one cycle |
| host_reg | input | 2 | Register index: 0 ptr low, 1 ptr high, 2 data, 3 control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid with host_rvalid |
| host_rvalid | output | 1 | High one cycle after a host read |
| ram_addr | output | 16 | RAM byte address (current pointer) |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after ram_re |
| cop_run | output | 1 | Coprocessor run enable |
| cop_reset | output | 1 | Coprocessor held in reset while high |
| cop_irq | output | 1 | One-cycle interrupt request to the coprocessor |
| evt_set | input | 2 | Coprocessor event strobes for the two flags |
| host_irq | output | 1 | Host interrupt, high while any flag is pending |

## Verification
Two functions can collide in one cycle: a coprocessor event strobe and a host control write that clears the same flag. The bench provokes this by raising `evt_set` in the exact cycle that it writes a one to the matching control bit. Afterwards it expects the flag still set, both in the control readback and on `host_irq`. A second collision mixes a strobe on one flag with a clear of the other, and the bench expects the two flags to resolve independently. Block transfers, including the transfer that crosses 0xFFFF, are judged by reading the pointer bytes back and re-reading the stored data.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    localparam int EV_N      = 2;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_AINC = 1;
    localparam int CTRL_IRQ  = 2;
    localparam int CTRL_EV0  = 4;

    typedef enum logic [1:0] {
        REG_PTR_LO = 2'd0,
        REG_PTR_HI = 2'd1,
        REG_DATA   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            run;
        logic            ainc;
        logic [EV_N-1:0] ev;
    } ctrl_t;

    typedef struct packed {
        logic            run_d;
        logic            ainc_d;
        logic            irq_d;
        logic [EV_N-1:0] clr;
    } ctrl_cmd_t;

    function automatic logic [7:0] pack_ctrl(ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CTRL_RUN]  = c.run;
        b[CTRL_AINC] = c.ainc;
        for (int i = 0; i < EV_N; i++) b[CTRL_EV0+i] = c.ev[i];
        return b;
    endfunction

    function automatic ctrl_cmd_t unpack_cmd(logic [7:0] w);
        ctrl_cmd_t c;
        c.run_d  = w[CTRL_RUN];
        c.ainc_d = w[CTRL_AINC];
        c.irq_d  = w[CTRL_IRQ];
        for (int i = 0; i < EV_N; i++) c.clr[i] = w[CTRL_EV0+i];
        return c;
    endfunction

endpackage

// File: rtl/cpx_addr_ptr.sv
module cpx_addr_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [7:0]        wbyte,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int HI_W = ADDR_W - 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ld_lo) begin
            addr_q[7:0] <= wbyte;
        end else if (ld_hi) begin
            addr_q[ADDR_W-1:8] <= wbyte[HI_W-1:0];
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpx_ctrl_regs.sv
module cpx_ctrl_regs
    import cpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  ctrl_cmd_t       cmd,
    input  logic [EV_N-1:0] evt_set,
    output ctrl_t           state,
    output logic            irq_q
);
    logic            run_q;
    logic            ainc_q;
    logic [EV_N-1:0] ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            ainc_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= wr_en & cmd.irq_d;
            if (wr_en) begin
                run_q  <= cmd.run_d;
                ainc_q <= cmd.ainc_d;
            end
        end
    end

    for (genvar i = 0; i < EV_N; i++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst)             ev_q[i] <= 1'b0;
            else if (evt_set[i]) ev_q[i] <= 1'b1;
            else if (wr_en && cmd.clr[i]) ev_q[i] <= 1'b0;
        end
    end

    always_comb begin
        state.run  = run_q;
        state.ainc = ainc_q;
        state.ev   = ev_q;
    end
endmodule

// File: rtl/cpx_read_port.sv
module cpx_read_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_reg,
    input  logic       rd_ram,
    input  logic [7:0] reg_byte,
    input  logic [7:0] ram_rdata,
    output logic [7:0] rdata,
    output logic       rvalid
);
    logic       from_ram_q;
    logic [7:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid     <= 1'b0;
            from_ram_q <= 1'b0;
            hold_q     <= '0;
        end else begin
            rvalid     <= rd_reg | rd_ram;
            from_ram_q <= rd_ram;
            if (rd_reg) hold_q <= reg_byte;
        end
    end

    assign rdata = from_ram_q ? ram_rdata : hold_q;
endmodule

// File: rtl/cpx_window.sv
module cpx_window
    import cpx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_reg,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              cop_run,
    output logic              cop_reset,
    output logic              cop_irq,
    input  logic [EV_N-1:0]   evt_set,
    output logic              host_irq
);
    reg_sel_e          sel;
    logic [ADDR_W-1:0] addr_q;
    logic              ainc;
    logic              data_hit;
    logic              step;
    logic              ctrl_wr;
    ctrl_t             state;
    logic [7:0]        reg_byte;

    assign sel      = reg_sel_e'(host_reg);
    assign data_hit = (sel == REG_DATA);
    assign ctrl_wr  = host_wr && (sel == REG_CTRL);
    assign ainc     = state.ainc;
    assign step     = (host_wr || host_rd) && data_hit && ainc;

    cpx_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld_lo  (host_wr && sel == REG_PTR_LO),
        .ld_hi  (host_wr && sel == REG_PTR_HI),
        .wbyte  (host_wdata),
        .step   (step),
        .addr_q (addr_q)
    );

    cpx_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr),
        .cmd     (unpack_cmd(host_wdata)),
        .evt_set (evt_set),
        .state   (state),
        .irq_q   (cop_irq)
    );

    always_comb begin
        unique case (sel)
            REG_PTR_LO: reg_byte = addr_q[7:0];
            REG_PTR_HI: reg_byte = 8'(addr_q[ADDR_W-1:8]);
            REG_CTRL:   reg_byte = pack_ctrl(state);
            default:    reg_byte = '0;
        endcase
    end

    cpx_read_port u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_reg    (host_rd && !data_hit),
        .rd_ram    (host_rd && data_hit),
        .reg_byte  (reg_byte),
        .ram_rdata (ram_rdata),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    assign ram_addr  = addr_q;
    assign ram_we    = host_wr && data_hit;
    assign ram_re    = host_rd && data_hit;
    assign ram_wdata = host_wdata;
    assign cop_run   = state.run;
    assign cop_reset = ~state.run;
    assign host_irq  = |state.ev;
endmodule

// File: rtl/cpx_window_chk.sv
module cpx_window_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        host_reg,
    input logic [7:0]        host_wdata,
    input logic              host_rvalid,
    input logic              ram_we,
    input logic              cop_run,
    input logic              cop_irq,
    input logic [1:0]        evt_set,
    input logic              host_irq,
    input logic [ADDR_W-1:0] addr_q,
    input logic              ainc
);
    p_rvalid_r4: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    p_we_src_r3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (host_wr && host_reg == 2'd2));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && host_reg == 2'd2 && ainc)
        |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && host_reg == 2'd2 && !ainc) |=> $stable(addr_q));

    p_run_r7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_reg == 2'd3) |=> cop_run == $past(host_wdata[0]));

    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        cop_irq |=> !cop_irq);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (evt_set != 2'b00) |=> host_irq);
endmodule

bind cpx_window cpx_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_reg    (host_reg),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .ram_we      (ram_we),
    .cop_run     (cop_run),
    .cop_irq     (cop_irq),
    .evt_set     (evt_set),
    .host_irq    (host_irq),
    .addr_q      (addr_q),
    .ainc        (ainc)
);

// File: tb/cpx_window_tb.sv
`timescale 1ns/1ps
module cpx_window_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_reg = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic [15:0] ram_addr;
    logic        ram_re, ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic        cop_run, cop_reset, cop_irq;
    logic [1:0]  evt_set = '0;
    logic        host_irq;

    logic        poke_we = 1'b0;
    logic [9:0]  poke_addr = '0;
    logic [7:0]  poke_data = '0;
    logic [7:0]  mem [0:1023];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct { string req; logic [7:0] val; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    cpx_window u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .ram_addr(ram_addr), .ram_re(ram_re),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .cop_run(cop_run), .cop_reset(cop_reset), .cop_irq(cop_irq),
        .evt_set(evt_set), .host_irq(host_irq)
    );

    // RAM model: 1024 bytes, address bits 9:0, one-cycle read latency
    always @(posedge clk) begin
        if (poke_we) mem[poke_addr] <= poke_data;
        else if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr[9:0]];
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read results
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check("unexpected read", host_rdata, 8'hxx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, host_rdata, e.val);
            end
        end
    end

    task automatic wr(logic [1:0] r, logic [7:0] d, logic [1:0] ev = 2'b00);
        @(negedge clk);
        host_wr = 1'b1; host_reg = r; host_wdata = d; evt_set = ev;
        @(negedge clk);
        host_wr = 1'b0; evt_set = 2'b00;
    endtask

    task automatic rd(logic [1:0] r, logic [7:0] e, string req);
        exp_t x;
        x.req = req; x.val = e;
        @(negedge clk);
        exp_q.push_back(x);
        host_rd = 1'b1; host_reg = r;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_ptr(logic [15:0] a);
        wr(2'd0, a[7:0]);
        wr(2'd1, a[15:8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cop_reset", {7'b0, cop_reset}, 8'h01);
        check("R1 cop_run",   {7'b0, cop_run},   8'h00);
        check("R1 host_irq",  {7'b0, host_irq},  8'h00);
        check("R1 cop_irq",   {7'b0, cop_irq},   8'h00);
        rd(2'd3, 8'h00, "R1 ctrl");
        rd(2'd0, 8'h00, "R1 ptr lo");

        // R2 pointer bytes
        set_ptr(16'h1234);
        rd(2'd0, 8'h34, "R2 lo");
        rd(2'd1, 8'h12, "R2 hi");

        // R3/R4/R5 with auto-increment off
        wr(2'd2, 8'hA5);
        rd(2'd2, 8'hA5, "R4 data readback");
        rd(2'd0, 8'h34, "R5 no increment");

        // R7 run, R12 readback
        wr(2'd3, 8'h03);
        check("R7 cop_run",   {7'b0, cop_run},   8'h01);
        check("R7 cop_reset", {7'b0, cop_reset}, 8'h00);
        rd(2'd3, 8'h03, "R12 ctrl run+ainc");

        // R5 block transfer
        set_ptr(16'h0100);
        for (int i = 0; i < 4; i++) wr(2'd2, 8'h50 + 8'(i));
        rd(2'd0, 8'h04, "R5 ptr after writes");
        set_ptr(16'h0100);
        for (int i = 0; i < 4; i++) rd(2'd2, 8'h50 + 8'(i), "R4 block read pre-increment");
        rd(2'd0, 8'h04, "R5 ptr after reads");

        // R6 wrap
        set_ptr(16'hFFFF);
        wr(2'd2, 8'h77);
        wr(2'd2, 8'h88);
        rd(2'd0, 8'h01, "R6 wrap lo");
        rd(2'd1, 8'h00, "R6 wrap hi");
        set_ptr(16'hFFFF);
        rd(2'd2, 8'h77, "R6 byte at FFFF");
        rd(2'd2, 8'h88, "R6 byte at 0000");

        // heartbeat round trip via data path (R3, R4)
        @(negedge clk); poke_we = 1'b1; poke_addr = 10'h020; poke_data = 8'hFF;
        @(negedge clk); poke_we = 1'b0;
        wr(2'd3, 8'h01);
        set_ptr(16'h0020);
        rd(2'd2, 8'hFF, "R4 heartbeat read");
        wr(2'd2, 8'h00);
        rd(2'd2, 8'h00, "R3 heartbeat cleared");

        // R8 irq pulse
        @(negedge clk);
        host_wr = 1'b1; host_reg = 2'd3; host_wdata = 8'h07;
        @(negedge clk);
        host_wr = 1'b0;
        check("R8 irq high", {7'b0, cop_irq}, 8'h01);
        @(negedge clk);
        check("R8 irq low", {7'b0, cop_irq}, 8'h00);
        rd(2'd3, 8'h03, "R8 irq bit reads 0");

        // R9 / R10 events
        @(negedge clk); evt_set = 2'b01;
        @(negedge clk); evt_set = 2'b00;
        check("R9 host_irq", {7'b0, host_irq}, 8'h01);
        rd(2'd3, 8'h13, "R9 ev0 flag");
        wr(2'd3, 8'h03);
        rd(2'd3, 8'h13, "R10 zero leaves flag");
        wr(2'd3, 8'h23);
        rd(2'd3, 8'h13, "R10 other clear leaves flag");
        wr(2'd3, 8'h13);
        check("R10 host_irq cleared", {7'b0, host_irq}, 8'h00);
        rd(2'd3, 8'h03, "R10 flag cleared");

        // R11 collisions
        wr(2'd3, 8'h23, 2'b10);
        check("R11 host_irq", {7'b0, host_irq}, 8'h01);
        rd(2'd3, 8'h23, "R11 set wins");
        wr(2'd3, 8'h23, 2'b01);
        rd(2'd3, 8'h13, "R11 set ev0 while clearing ev1");
        wr(2'd3, 8'h10);
        check("R7 halted", {7'b0, cop_reset}, 8'h01);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) check("reads outstanding", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule